// File: doc/BRIEF.md
# FIFO Read-Pointer Rewind Controller

This block holds the read and write pointers of a single-clock FIFO and derives the fill count and the empty and full flags from them. It adds a rewind feature. When the active-low `rewind_n` input is sampled low, the read pointer returns to storage location zero. A consumer can then acknowledge a packet, or ask for it again and read the same words a second time. The memory array sits outside the block and is addressed through `rd_addr` and `wr_addr`.

A rewind is honoured only under two conditions. The write pointer must not yet have wrapped, meaning at most `DEPTH` words have been written since reset. At least one word must have been read since reset. A request that breaks either rule leaves the read pointer where it is and raises `rewind_err` for one cycle. While `rewind_n` is low, both enables are ignored, which serves as the quiet window around the pulse. After a rewind, reads walk forward from location zero up to the write pointer. Words written later follow in order.

Top module: `rtx_ctrl`

## Requirements
- R1: Asynchronous active-low reset clears both pointers, making `rd_addr`=0, `wr_addr`=0, `count`=0, `empty`=1, `full`=0 and `rewind_err`=0.
- R2: A clock edge with `wr_en`=1, `rewind_n`=1 and `full`=0 advances `wr_addr` by one, modulo `DEPTH`. With `full`=1 the write is ignored and `wr_addr` and `count` hold.
- R3: A clock edge with `rd_en`=1, `rewind_n`=1 and `empty`=0 advances `rd_addr` by one, modulo `DEPTH`. With `empty`=1 the read is ignored.
- R4: An edge with `rewind_n`=0 is a valid rewind when two conditions hold: at most `DEPTH` writes have been accepted since reset, and at least one read has been accepted since reset. After a valid rewind, `rd_addr`=0 and `count` equals the number of writes accepted since reset.
- R5: While `rewind_n`=0, `wr_en` and `rd_en` have no effect. `wr_addr` is unchanged, and no read advances the pointer.
- R6: If more than `DEPTH` writes have been accepted since reset, an edge with `rewind_n`=0 sets `rewind_err`=1 for the following cycle.
- R7: If no read has been accepted since reset, an edge with `rewind_n`=0 sets `rewind_err`=1 for the following cycle.
- R8: A rejected rewind leaves `rd_addr` and `count` unchanged. `rewind_err` is 0 after any edge where the rewind is valid or `rewind_n`=1.
- R9: `count` is the write pointer minus the read pointer, never exceeding `DEPTH`. `empty` is 1 exactly when `count`=0, and `full` is 1 exactly when `count`=`DEPTH`. All three reflect a rewind in the cycle after it.
- R10: After a rewind, consecutive reads present addresses 0, 1, 2 … up to the write pointer and then report empty. Words written after the rewind are read next, in write order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Read request |
| rewind_n | input | 1 | Active-low rewind request, sampled on the clock |
| wr_addr | output | $clog2(DEPTH) | Storage location for the next write |
| rd_addr | output | $clog2(DEPTH) | Storage location for the next read |
| count | output | $clog2(DEPTH)+1 | Words held |
| empty | output | 1 | No word held |
| full | output | 1 | DEPTH words held |
| rewind_err | output | 1 | Previous edge carried a rejected rewind |

## Verification
A corrupted read pointer shows on `rd_addr` and `count` in the very next cycle. A stale write tally or read-seen flag is hidden until the next rewind request. At that request it appears either as a missing `rewind_err` with a spurious return of `rd_addr` to zero, or as a wrong `rewind_err` with the pointer left in place. The reference model is compared on every clock, so a rewind taken on an invalid request is caught one cycle after the request edge. A replay that skips or repeats a location is caught at the first mismatched address.

// File: rtl/rtx_pkg.sv
package rtx_pkg;
    // Classification of the rewind input on a given edge.
    typedef enum logic [1:0] {
        RW_IDLE   = 2'b00,
        RW_TAKE   = 2'b01,
        RW_REJECT = 2'b10
    } rw_kind_t;

    function automatic rw_kind_t classify(input logic req, input logic ok);
        if (!req)
            return RW_IDLE;
        else if (ok)
            return RW_TAKE;
        else
            return RW_REJECT;
    endfunction
endpackage

// File: rtl/rtx_ptr.sv
module rtx_ptr #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] ptr
);
    typedef struct packed {
        logic [W-1:0] p;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr)
            st_d.p = '0;
        else if (inc)
            st_d.p = st_q.p + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign ptr = st_q.p;

    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> ptr == '0);
    p_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr) |=> ptr == $past(ptr) + W'(1));
    p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !clr) |=> $stable(ptr));
endmodule

// File: rtl/rtx_track.sv
module rtx_track #(
    parameter int DEPTH = 16,
    localparam int TW = $clog2(DEPTH + 2)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_fire,
    input  logic rd_fire,
    output logic rewind_ok
);
    localparam logic [TW-1:0] LIMIT = TW'(DEPTH);

    typedef struct packed {
        logic [TW-1:0] total;  // saturates at DEPTH+1
        logic          seen;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_fire && st_q.total <= LIMIT)
            st_d.total = st_q.total + TW'(1);
        if (rd_fire)
            st_d.seen = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign rewind_ok = st_q.seen && (st_q.total <= LIMIT);

    p_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.total <= LIMIT + TW'(1));
    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.seen |=> st_q.seen);
    p_lost_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rewind_ok && st_q.seen |=> !rewind_ok);
endmodule

// File: rtl/rtx_flags.sv
module rtx_flags #(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [AW:0] wptr,
    input  logic [AW:0] rptr,
    output logic [AW:0] count,
    output logic        empty,
    output logic        full
);
    localparam logic [AW:0] FULLV = (AW+1)'(DEPTH);

    always_comb begin
        count = wptr - rptr;
        empty = (count == '0);
        full  = (count == FULLV);
    end

    p_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULLV);
endmodule

// File: rtl/rtx_ctrl.sv
module rtx_ctrl
    import rtx_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic          rewind_n,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr,
    output logic [AW:0]   count,
    output logic          empty,
    output logic          full,
    output logic          rewind_err
);
    typedef struct packed {
        logic err;
    } st_t;

    st_t      st_d, st_q;
    logic     rewind_ok;
    logic     wr_fire, rd_fire, take;
    rw_kind_t kind;
    logic [AW:0] wptr, rptr;

    always_comb begin
        kind    = classify(!rewind_n, rewind_ok);
        take    = (kind == RW_TAKE);
        wr_fire = rewind_n && wr_en && !full;
        rd_fire = rewind_n && rd_en && !empty;
        st_d     = st_q;
        st_d.err = (kind == RW_REJECT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    rtx_ptr #(.W(AW+1)) u_wptr (
        .clk(clk), .rst_n(rst_n), .inc(wr_fire), .clr(1'b0), .ptr(wptr)
    );

    rtx_ptr #(.W(AW+1)) u_rptr (
        .clk(clk), .rst_n(rst_n), .inc(rd_fire), .clr(take), .ptr(rptr)
    );

    rtx_track #(.DEPTH(DEPTH)) u_track (
        .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .rd_fire(rd_fire),
        .rewind_ok(rewind_ok)
    );

    rtx_flags #(.DEPTH(DEPTH)) u_flags (
        .clk(clk), .rst_n(rst_n), .wptr(wptr), .rptr(rptr),
        .count(count), .empty(empty), .full(full)
    );

    assign wr_addr    = wptr[AW-1:0];
    assign rd_addr    = rptr[AW-1:0];
    assign rewind_err = st_q.err;

    p_rewind_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!rewind_n && rewind_ok) |=> (rd_addr == '0 && !rewind_err));
    p_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rewind_n |=> $stable(wr_addr));
    p_reject_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!rewind_n && !rewind_ok) |=> (rewind_err && $stable(rd_addr) && $stable(count)));
    p_noerr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rewind_n |=> !rewind_err);
    p_nowrite_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
        full |=> $stable(wr_addr));
endmodule

// File: tb/rtx_ctrl_test.sv
module rtx_ctrl_test;
    localparam int DEPTH = 16;
    localparam int AW = $clog2(DEPTH);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, rd_en = 1'b0, rewind_n = 1'b1;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [AW:0] count;
    logic empty, full, rewind_err;

    int vectors = 0;
    int fails = 0;
    int cycles = 0;
    int m_wr = 0, m_rd = 0, m_tot = 0, m_err = 0;
    bit m_seen = 0;
    int seq[$];

    always #10 clk = ~clk;

    rtx_ctrl #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .rewind_n(rewind_n), .wr_addr(wr_addr), .rd_addr(rd_addr),
        .count(count), .empty(empty), .full(full), .rewind_err(rewind_err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    // Behavioural reference model.
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_wr = 0; m_rd = 0; m_tot = 0; m_seen = 0; m_err = 0;
        end else if (!rewind_n) begin
            if (m_seen && m_tot <= DEPTH) begin
                m_rd = 0; m_err = 0;
            end else begin
                m_err = 1;
            end
        end else begin
            bit rf, wf;
            m_err = 0;
            rf = rd_en && (m_wr != m_rd);
            wf = wr_en && (m_wr - m_rd != DEPTH);
            if (rf) begin m_rd++; m_seen = 1; end
            if (wf) begin m_wr++; m_tot++; end
        end
    end

    // Every-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R3/R10 rd_addr", int'(rd_addr), m_rd % DEPTH);
            chk("R2/R5 wr_addr", int'(wr_addr), m_wr % DEPTH);
            chk("R9 count", int'(count), m_wr - m_rd);
            chk("R9 empty", int'(empty), int'(m_wr == m_rd));
            chk("R9 full", int'(full), int'(m_wr - m_rd == DEPTH));
            chk("R6/R7/R8 rewind_err", int'(rewind_err), m_err);
            if (rd_en && rewind_n && !empty) seq.push_back(int'(rd_addr));
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected < 20000", cycles);
            finish_run();
        end
    end

    task automatic step(input logic w, input logic r, input logic rt);
        @(negedge clk);
        wr_en = w; rd_en = r; rewind_n = rt;
    endtask

    task automatic do_reset();
        @(negedge clk);
        wr_en = 0; rd_en = 0; rewind_n = 1;
        rst_n = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1;
    endtask

    initial begin
        do_reset();
        @(negedge clk);
        // R1: reset state
        chk("R1 rd_addr", int'(rd_addr), 0);
        chk("R1 wr_addr", int'(wr_addr), 0);
        chk("R1 count", int'(count), 0);
        chk("R1 empty", int'(empty), 1);
        chk("R1 full", int'(full), 0);
        chk("R1 rewind_err", int'(rewind_err), 0);

        // R3: read on empty ignored
        step(0, 1, 1);
        step(0, 0, 1);
        @(negedge clk);
        chk("R3 empty read ignored", int'(rd_addr), 0);

        for (int i = 0; i < 10; i++) step(1, 0, 1);
        for (int i = 0; i < 4; i++) step(0, 1, 1);
        // R5: enables asserted during rewind must be ignored
        step(1, 1, 0);
        step(1, 1, 0);
        step(0, 0, 1);
        @(negedge clk);
        chk("R4 rd_addr after rewind", int'(rd_addr), 0);
        chk("R4 count after rewind", int'(count), 10);
        chk("R5 wr_addr held", int'(wr_addr), 10);

        // R10: replay from location 0
        seq.delete();
        for (int i = 0; i < 12; i++) step(0, 1, 1);
        step(0, 0, 1);
        @(negedge clk);
        chk("R10 replay length", seq.size(), 10);
        for (int i = 0; i < seq.size(); i++) chk("R10 replay address", seq[i], i);
        chk("R10 empty after replay", int'(empty), 1);

        // R10: later writes delivered in order
        seq.delete();
        for (int i = 0; i < 3; i++) step(1, 0, 1);
        for (int i = 0; i < 3; i++) step(0, 1, 1);
        step(0, 0, 1);
        @(negedge clk);
        chk("R10 later words count", seq.size(), 3);
        for (int i = 0; i < seq.size(); i++) chk("R10 later word address", seq[i], 10 + i);

        // R4/R9: second rewind, count 13
        step(0, 0, 0);
        step(0, 0, 1);
        @(negedge clk);
        chk("R9 count after second rewind", int'(count), 13);
        chk("R9 empty after second rewind", int'(empty), 0);

        // R2: fill to full, extra writes ignored
        for (int i = 0; i < 5; i++) step(1, 0, 1);
        step(0, 0, 1);
        @(negedge clk);
        chk("R2 full flag", int'(full), 1);
        chk("R2 wr_addr at full", int'(wr_addr), 0);

        // R6/R8: exceed DEPTH writes, rewind rejected
        step(0, 1, 1);
        step(1, 0, 1);
        step(0, 0, 0);
        step(0, 0, 1);
        chk("R6 rewind_err", int'(rewind_err), 1);
        chk("R8 rd_addr kept", int'(rd_addr), 1);
        @(negedge clk);
        chk("R8 err clears", int'(rewind_err), 0);

        // R7: rewind with no read since reset
        do_reset();
        for (int i = 0; i < 3; i++) step(1, 0, 1);
        step(0, 0, 0);
        step(0, 0, 1);
        chk("R7 rewind_err", int'(rewind_err), 1);
        chk("R8 count kept", int'(count), 3);

        step(0, 0, 1);
        @(negedge clk);
        finish_run();
    end
endmodule